// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block sits between the schedule walker of a host controller and its bus transaction engine. When the walker has fetched a transfer descriptor, it presents the descriptor's 32-bit control word and 32-bit token. It also presents the result of the bus transaction that the descriptor described: a success with a byte count, a stall, a NAK, babble, or an error or missing response. The block then works out how the descriptor's control word must be rewritten and what the walker should do next. The walker can advance the queue, skip to the next queue, or abandon the rest of the frame. The block also reports which interrupt causes the frame has collected.

The token is decoded without delay into the packet identifier, device address, endpoint and maximum transfer length, so the transaction issuer can start the bus transaction from the same fetch. The status update itself is registered. A one-cycle start strobe loads the inputs, and the results appear on the next cycle with a one-cycle done pulse. They stay unchanged until the next start. Lengths on both the token and the control word use the n−1 encoding in 11 bits, so the all-ones value stands for zero bytes.

Top module: `td_status_update`

## Requirements
- R1: The decode outputs follow the token directly, with no clock. The fields are: packet identifier from bits 7:0, device address from bits 14:8, endpoint from bits 18:15, and maximum length equal to (bits 31:21 + 1) modulo 2048, so 0x7FF gives 0 bytes.
- R2: The result fields are `result_i` and `disp_o`.
  - `result_i`: 0 success, 1 stall, 2 NAK, 3 babble, 4 error or no response.
  - `disp_o`: 0 advance, 1 skip, 2 abort frame.
  - A start strobe produces `done_o` high for exactly the next cycle. All status outputs update on that cycle and hold until the next start. After reset every output register is zero.
- R3: If control bit 23 (active) is clear, the result is skip. The control word is returned unchanged, with no interrupt cause and no error flags, whatever the outcome input.
- R4: An active descriptor whose packet identifier is not IN (0x69), OUT (0xE1) or SETUP (0x2D) raises `proc_err_o` and returns abort. The control word is left unchanged.
- R5: For an active descriptor with a valid identifier:
  - Bit 24 (interrupt on complete) sets interrupt cause bit 0, whatever the outcome.
  - Bit 25 (isochronous select) clears the active bit.
- R6: On success, control bits 10:0 receive (byte count − 1) modulo 2048. Bits 23 (active) and 19 (NAK) are cleared, and the result is advance unless R7 or R8 applies.
- R7: On a successful IN whose byte count exceeds the maximum length, bits 20 (babble) and 22 (stall) are set, active is cleared, and the result is abort.
- R8: On a successful IN with bit 29 (short-packet detect) set and fewer bytes than the maximum, interrupt cause bit 1 is set and the result is skip.
- R9: A stall outcome sets bit 22, clears active and returns skip. A babble outcome sets bits 20 and 22, clears active and returns abort.
- R10: A NAK outcome on an IN or OUT sets bit 19, keeps active and returns skip.
- R11: An error outcome, or a NAK to a SETUP, takes the error path, which returns skip:
  - Bit 18 (timeout) is set.
  - If the error count in bits 28:27 is nonzero it is decremented.
  - If the decrement reaches zero, active is cleared and `usb_err_o` is raised.
  - A count that is already zero stays zero and leaves active set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Load descriptor and outcome for update |
| ctrl_i | input | 32 | Descriptor control word |
| token_i | input | 32 | Descriptor token |
| result_i | input | 3 | Transaction outcome code |
| count_i | input | 12 | Bytes transferred on success |
| pid_o | output | 8 | Decoded packet identifier |
| dev_addr_o | output | 7 | Decoded device address |
| endp_o | output | 4 | Decoded endpoint |
| max_len_o | output | 11 | Decoded maximum length in bytes |
| done_o | output | 1 | Status outputs valid this cycle |
| ctrl_o | output | 32 | Updated control word |
| disp_o | output | 2 | Queue disposition |
| int_cause_o | output | 2 | Interrupt causes (bit 0 completion, bit 1 short packet) |
| usb_err_o | output | 1 | Error count exhausted |
| proc_err_o | output | 1 | Invalid packet identifier |

## Verification
Several groups of descriptors are presented to the block:
- **Inactive descriptor with a hostile outcome.** This shows that the active bit gates the whole update.
- **Unknown identifier.** This separates the process-error abort from every outcome-driven path.
- **Successful transfers.** These cover exact, zero, oversize and short IN counts, with and without short-packet detect. They separate advance, skip and the babble abort.
- **Stall, babble and NAK outcomes.** NAKs are given on IN and on SETUP, which shows the SETUP case being diverted to the error path.
- **Error outcomes at error counts 3, 1 and 0.** These separate plain decrement, exhaustion with the error flag, and the stuck-at-zero case.

// File: rtl/td_pkg.sv
// Shared encodings for the transfer descriptor status updater.
// Assumes the 32-bit control/token layouts fixed by the schedule format.
package td_pkg;
    localparam int LEN_W = 11;
    localparam int CNT_W = LEN_W + 1;

    // control word bit positions
    localparam int B_TIMEOUT = 18;
    localparam int B_NAK     = 19;
    localparam int B_BABBLE  = 20;
    localparam int B_STALL   = 22;
    localparam int B_ACTIVE  = 23;
    localparam int B_IOC     = 24;
    localparam int B_ISO     = 25;
    localparam int B_ERR_LO  = 27;
    localparam int B_ERR_HI  = 28;
    localparam int B_SPD     = 29;

    localparam logic [7:0] PID_IN    = 8'h69;
    localparam logic [7:0] PID_OUT   = 8'hE1;
    localparam logic [7:0] PID_SETUP = 8'h2D;

    typedef enum logic [2:0] {
        RES_OK     = 3'd0,
        RES_STALL  = 3'd1,
        RES_NAK    = 3'd2,
        RES_BABBLE = 3'd3,
        RES_ERROR  = 3'd4
    } result_e;

    typedef enum logic [1:0] {
        DISP_ADVANCE = 2'd0,
        DISP_SKIP    = 2'd1,
        DISP_ABORT   = 2'd2
    } disp_e;
endpackage

// File: rtl/td_token_decode.sv
// Splits a descriptor token into the fields the transaction issuer needs.
// Assumes the length field uses the n-1 encoding, all ones meaning zero.
module td_token_decode
    import td_pkg::*;
(
    input  logic [31:0]      token_i,
    output logic [7:0]       pid_o,
    output logic [6:0]       dev_addr_o,
    output logic [3:0]       endp_o,
    output logic [LEN_W-1:0] max_len_o
);
    // field extraction and n-1 length conversion
    always_comb begin
        pid_o      = token_i[7:0];
        dev_addr_o = token_i[14:8];
        endp_o     = token_i[18:15];
        max_len_o  = token_i[31:21] + 1'b1;
    end
endmodule

// File: rtl/td_outcome_eval.sv
// Combinational update of a descriptor control word from a transaction result.
// Assumes inputs are stable while evaluated; produces word, disposition, causes.
module td_outcome_eval
    import td_pkg::*;
(
    input  logic [31:0]      ctrl_i,
    input  logic [7:0]       pid_i,
    input  logic [LEN_W-1:0] max_len_i,
    input  logic [2:0]       result_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [31:0]      ctrl_o,
    output logic [1:0]       disp_o,
    output logic [1:0]       cause_o,
    output logic             usb_err_o,
    output logic             proc_err_o
);
    logic pid_ok, is_in, is_setup, err_path;
    logic [1:0] err_cnt;
    logic [CNT_W-1:0] max_ext;

    // identifier classification
    always_comb begin
        is_in    = (pid_i == PID_IN);
        is_setup = (pid_i == PID_SETUP);
        pid_ok   = is_in || is_setup || (pid_i == PID_OUT);
        max_ext  = {1'b0, max_len_i};
    end

    // outcome-driven rewrite of the control word
    always_comb begin
        ctrl_o     = ctrl_i;
        disp_o     = DISP_SKIP;
        cause_o    = 2'b00;
        usb_err_o  = 1'b0;
        proc_err_o = 1'b0;
        err_path   = 1'b0;
        err_cnt    = ctrl_i[B_ERR_HI:B_ERR_LO];
        if (!ctrl_i[B_ACTIVE]) begin
            disp_o = DISP_SKIP;
        end else if (!pid_ok) begin
            disp_o     = DISP_ABORT;
            proc_err_o = 1'b1;
        end else begin
            if (ctrl_i[B_IOC]) cause_o[0] = 1'b1;
            if (ctrl_i[B_ISO]) ctrl_o[B_ACTIVE] = 1'b0;
            case (result_i)
                RES_OK: begin
                    ctrl_o[LEN_W-1:0] = LEN_W'(count_i - 1'b1);
                    ctrl_o[B_ACTIVE]  = 1'b0;
                    ctrl_o[B_NAK]     = 1'b0;
                    disp_o            = DISP_ADVANCE;
                    if (is_in && (count_i > max_ext)) begin
                        ctrl_o[B_BABBLE] = 1'b1;
                        ctrl_o[B_STALL]  = 1'b1;
                        disp_o           = DISP_ABORT;
                    end else if (is_in && ctrl_i[B_SPD] && (count_i < max_ext)) begin
                        cause_o[1] = 1'b1;
                        disp_o     = DISP_SKIP;
                    end
                end
                RES_STALL: begin
                    ctrl_o[B_STALL]  = 1'b1;
                    ctrl_o[B_ACTIVE] = 1'b0;
                end
                RES_NAK: begin
                    ctrl_o[B_NAK] = 1'b1;
                    if (is_setup) err_path = 1'b1;
                end
                RES_BABBLE: begin
                    ctrl_o[B_BABBLE] = 1'b1;
                    ctrl_o[B_STALL]  = 1'b1;
                    ctrl_o[B_ACTIVE] = 1'b0;
                    disp_o           = DISP_ABORT;
                end
                default: err_path = 1'b1;
            endcase
            if (err_path) begin
                ctrl_o[B_TIMEOUT] = 1'b1;
                if (err_cnt != 2'd0) begin
                    err_cnt = err_cnt - 1'b1;
                    ctrl_o[B_ERR_HI:B_ERR_LO] = err_cnt;
                    if (err_cnt == 2'd0) begin
                        ctrl_o[B_ACTIVE] = 1'b0;
                        usb_err_o        = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/td_status_update.sv
// Top of the descriptor status updater: live token decode plus a registered
// status update loaded by a start strobe. Assumes one update per start.
module td_status_update
    import td_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [31:0]      ctrl_i,
    input  logic [31:0]      token_i,
    input  logic [2:0]       result_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [7:0]       pid_o,
    output logic [6:0]       dev_addr_o,
    output logic [3:0]       endp_o,
    output logic [LEN_W-1:0] max_len_o,
    output logic             done_o,
    output logic [31:0]      ctrl_o,
    output logic [1:0]       disp_o,
    output logic [1:0]       int_cause_o,
    output logic             usb_err_o,
    output logic             proc_err_o
);
    logic [31:0] nxt_ctrl;
    logic [1:0]  nxt_disp, nxt_cause;
    logic        nxt_uerr, nxt_perr;

    td_token_decode i_dec (
        .token_i    (token_i),
        .pid_o      (pid_o),
        .dev_addr_o (dev_addr_o),
        .endp_o     (endp_o),
        .max_len_o  (max_len_o)
    );

    td_outcome_eval i_eval (
        .ctrl_i     (ctrl_i),
        .pid_i      (pid_o),
        .max_len_i  (max_len_o),
        .result_i   (result_i),
        .count_i    (count_i),
        .ctrl_o     (nxt_ctrl),
        .disp_o     (nxt_disp),
        .cause_o    (nxt_cause),
        .usb_err_o  (nxt_uerr),
        .proc_err_o (nxt_perr)
    );

    // result registers, loaded on start, done pulse one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            ctrl_o      <= '0;
            disp_o      <= '0;
            int_cause_o <= '0;
            usb_err_o   <= 1'b0;
            proc_err_o  <= 1'b0;
        end else begin
            done_o <= start_i;
            if (start_i) begin
                ctrl_o      <= nxt_ctrl;
                disp_o      <= nxt_disp;
                int_cause_o <= nxt_cause;
                usb_err_o   <= nxt_uerr;
                proc_err_o  <= nxt_perr;
            end
        end
    end
endmodule

// File: rtl/td_status_chk.sv
// Protocol checks for td_status_update, attached with bind.
module td_status_chk
    import td_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [31:0] ctrl_i,
    input logic [31:0] token_i,
    input logic [2:0]  result_i,
    input logic        done_o,
    input logic [31:0] ctrl_o,
    input logic [1:0]  disp_o,
    input logic [1:0]  int_cause_o,
    input logic        usb_err_o,
    input logic        proc_err_o
);
    logic pid_known;
    always_comb pid_known = (token_i[7:0] == 8'h69) || (token_i[7:0] == 8'hE1) ||
                            (token_i[7:0] == 8'h2D);

    a_r2_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);
    a_r3_inactive_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !ctrl_i[23]) |=> (disp_o == 2'd1) && (ctrl_o == $past(ctrl_i)));
    a_r4_bad_pid_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && ctrl_i[23] && !pid_known) |=> proc_err_o && (disp_o == 2'd2));
    a_r5_ioc_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && ctrl_i[23] && ctrl_i[24] && pid_known) |=> int_cause_o[0]);
    a_r9_stall_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && ctrl_i[23] && pid_known && result_i == 3'd1)
        |=> ctrl_o[22] && !ctrl_o[23] && (disp_o == 2'd1));
    a_r11_exhausted_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && usb_err_o) |-> !ctrl_o[23] && (ctrl_o[28:27] == 2'd0));
endmodule

bind td_status_update td_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .ctrl_i      (ctrl_i),
    .token_i     (token_i),
    .result_i    (result_i),
    .done_o      (done_o),
    .ctrl_o      (ctrl_o),
    .disp_o      (disp_o),
    .int_cause_o (int_cause_o),
    .usb_err_o   (usb_err_o),
    .proc_err_o  (proc_err_o)
);

// File: tb/test_td_status_update.sv
// Scoreboard bench: the driver computes expected results from the
// requirements and queues them; the monitor compares on each done pulse.
module test_td_status_update;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [1:0]  disp;
        logic [1:0]  cause;
        logic        uerr;
        logic        perr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] ctrl_i = '0, token_i = '0;
    logic [2:0]  result_i = '0;
    logic [11:0] count_i = '0;
    logic [7:0]  pid_o;
    logic [6:0]  dev_addr_o;
    logic [3:0]  endp_o;
    logic [10:0] max_len_o;
    logic        done_o, usb_err_o, proc_err_o;
    logic [31:0] ctrl_o;
    logic [1:0]  disp_o, int_cause_o;

    int checks = 0, errors = 0;
    bit finished = 0;
    exp_t sb_q[$];
    string tag_q[$];

    td_status_update i_td_status_update (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] tok(logic [7:0] pid, logic [6:0] a, logic [3:0] ep, logic [10:0] m1);
        return {m1, 2'b00, ep, a, pid};
    endfunction

    // expected result, from the requirements
    function automatic exp_t model(logic [31:0] c, logic [31:0] t, logic [2:0] r, logic [11:0] n);
        exp_t e;
        logic [11:0] mx;
        logic [1:0] ec;
        logic ep;
        e = '{ctrl: c, disp: 2'd1, cause: 2'b00, uerr: 1'b0, perr: 1'b0};
        mx = {1'b0, 11'(t[31:21] + 11'd1)};
        ep = 1'b0;
        if (!c[23]) return e;
        if (t[7:0] != 8'h69 && t[7:0] != 8'hE1 && t[7:0] != 8'h2D) begin
            e.disp = 2'd2; e.perr = 1'b1; return e;
        end
        if (c[24]) e.cause[0] = 1'b1;
        if (c[25]) e.ctrl[23] = 1'b0;
        if (r == 3'd0) begin
            e.ctrl[10:0] = 11'(n - 12'd1);
            e.ctrl[23] = 1'b0; e.ctrl[19] = 1'b0; e.disp = 2'd0;
            if (t[7:0] == 8'h69 && n > mx) begin
                e.ctrl[20] = 1'b1; e.ctrl[22] = 1'b1; e.disp = 2'd2;
            end else if (t[7:0] == 8'h69 && c[29] && n < mx) begin
                e.cause[1] = 1'b1; e.disp = 2'd1;
            end
        end else if (r == 3'd1) begin
            e.ctrl[22] = 1'b1; e.ctrl[23] = 1'b0;
        end else if (r == 3'd2) begin
            e.ctrl[19] = 1'b1;
            if (t[7:0] == 8'h2D) ep = 1'b1;
        end else if (r == 3'd3) begin
            e.ctrl[20] = 1'b1; e.ctrl[22] = 1'b1; e.ctrl[23] = 1'b0; e.disp = 2'd2;
        end else ep = 1'b1;
        if (ep) begin
            e.ctrl[18] = 1'b1;
            ec = c[28:27];
            if (ec != 2'd0) begin
                ec = ec - 2'd1;
                e.ctrl[28:27] = ec;
                if (ec == 2'd0) begin e.ctrl[23] = 1'b0; e.uerr = 1'b1; end
            end
        end
        return e;
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // driver: push expectation, pulse start for one cycle
    task automatic apply(string req, logic [31:0] c, logic [31:0] t, logic [2:0] r, logic [11:0] n);
        @(negedge clk);
        ctrl_i = c; token_i = t; result_i = r; count_i = n;
        sb_q.push_back(model(c, t, r, n));
        tag_q.push_back(req);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // monitor: compare each completed update against the scoreboard
    always @(negedge clk) begin
        if (done_o) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2", "unexpected done", 64'(done_o), 64'd0);
            end else begin
                exp_t e;
                string q;
                e = sb_q.pop_front();
                q = tag_q.pop_front();
                check(ctrl_o == e.ctrl, q, "ctrl", 64'(ctrl_o), 64'(e.ctrl));
                check(disp_o == e.disp && int_cause_o == e.cause &&
                      usb_err_o == e.uerr && proc_err_o == e.perr, q,
                      "disp/cause/uerr/perr",
                      64'({disp_o, int_cause_o, usb_err_o, proc_err_o}),
                      64'({e.disp, e.cause, e.uerr, e.perr}));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    localparam logic [31:0] ACT = 32'h0080_0000;
    localparam logic [31:0] IOC = 32'h0100_0000;
    localparam logic [31:0] ISO = 32'h0200_0000;
    localparam logic [31:0] SPD = 32'h2000_0000;
    localparam logic [31:0] NAKB = 32'h0008_0000;

    initial begin
        repeat (3) @(negedge clk);
        check(done_o == 1'b0 && ctrl_o == 32'h0 && disp_o == 2'd0, "R2", "reset state",
              64'({done_o, ctrl_o, disp_o}), 64'd0);
        rst_n = 1'b1;

        // R1 decode
        @(negedge clk);
        token_i = tok(8'hE1, 7'h5A, 4'hB, 11'd63); #1;
        check(pid_o == 8'hE1 && dev_addr_o == 7'h5A && endp_o == 4'hB && max_len_o == 11'd64,
              "R1", "decode", 64'({pid_o, dev_addr_o, endp_o, max_len_o}),
              64'({8'hE1, 7'h5A, 4'hB, 11'd64}));
        token_i = tok(8'h69, 7'h01, 4'h0, 11'h7FF); #1;
        check(max_len_o == 11'd0, "R1", "zero-length encoding", 64'(max_len_o), 64'd0);

        apply("R3", 32'h1234_5678 & ~ACT, tok(8'h55, 7'd1, 4'd1, 11'd7), 3'd4, 12'd3);
        // R2: done is a single pulse, outputs held
        @(negedge clk);
        check(done_o == 1'b0 && ctrl_o == (32'h1234_5678 & ~ACT), "R2", "done pulse / hold",
              64'({done_o, ctrl_o}), 64'({1'b0, 32'h1234_5678 & ~ACT}));
        apply("R4", ACT | IOC, tok(8'h55, 7'd3, 4'd2, 11'd7), 3'd0, 12'd8);
        apply("R5 R6", ACT | IOC | 32'h18000000, tok(8'hE1, 7'd2, 4'd1, 11'd7), 3'd0, 12'd8);
        apply("R6", ACT | NAKB, tok(8'h69, 7'd2, 4'd1, 11'h7FF), 3'd0, 12'd0);
        apply("R7", ACT | SPD, tok(8'h69, 7'd4, 4'd3, 11'd63), 3'd0, 12'd65);
        apply("R8", ACT | SPD | IOC, tok(8'h69, 7'd4, 4'd3, 11'd63), 3'd0, 12'd10);
        apply("R8", ACT, tok(8'h69, 7'd4, 4'd3, 11'd63), 3'd0, 12'd10);
        apply("R9", ACT | IOC, tok(8'hE1, 7'd4, 4'd3, 11'd63), 3'd1, 12'd0);
        apply("R9", ACT, tok(8'h69, 7'd4, 4'd3, 11'd63), 3'd3, 12'd0);
        apply("R10", ACT | 32'h18000000, tok(8'h69, 7'd6, 4'd5, 11'd7), 3'd2, 12'd0);
        apply("R5", ACT | ISO, tok(8'h69, 7'd6, 4'd5, 11'd7), 3'd2, 12'd0);
        apply("R11", ACT | 32'h18000000, tok(8'h2D, 7'd0, 4'd0, 11'd7), 3'd2, 12'd0);
        apply("R11", ACT | 32'h08000000, tok(8'hE1, 7'd9, 4'd1, 11'd7), 3'd4, 12'd0);
        apply("R11", ACT, tok(8'hE1, 7'd9, 4'd1, 11'd7), 3'd4, 12'd0);

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R2", "all results seen", 64'(sb_q.size()), 64'd0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule